// File: doc/BRIEF.md
# Parallel Tile Convolution Engine

The engine computes a 2-D convolution of a pre-padded image tile that sits in a local buffer. Software-visible setup is reduced to a handful of inputs: filter edge (1, 2 or 3), stride (1 or 2), tile width and height, and a signed bias. These are captured by a single start pulse. A scheduler cuts the output plane into row segments of up to sixteen outputs and hands each segment to one processing element (PE) in a bank of one to four. The bank size is fixed at build time.

Each PE walks its segment one output at a time. It reads pixels and weights through its own combinational read port, accumulates signed 8-bit products on top of the bias, and posts each finished 32-bit sum to a shared write port. When a PE retires its segment, the scheduler gives it the next one. A single-cycle done pulse marks the point at which every segment has been written back.

Top module: `conv_tile_engine`

## Requirements
- R1: After reset, and while no job has been started, `wr_en` and `done` stay low.
- R2: A job writes exactly OW×OH results, one to each address `oy*OW+ox`. OW = floor((W−K)/S)+1 and OH = floor((H−K)/S)+1.
- R3: The result at (oy,ox) equals bias + Σ pix[(oy·S+ky)·W + ox·S+kx] · wgt[ky·K+kx] over ky,kx in 0..K−1. Pixels and weights are signed 8-bit and the sum is a 32-bit signed value.
- R4: `filt_k` holds K directly (1, 2 or 3), and the weight index presented on `wgt_idx` is ky·K+kx.
- R5: `stride_sel` = 0 selects stride 1 and `stride_sel` = 1 selects stride 2.
- R6: Segments are issued in raster order, so the first result written by a job is address 0. Each segment goes to the lowest-numbered idle PE.
- R7: Up to NUM_PE segments are processed concurrently. At most one result is written per cycle, and simultaneous requests are granted lowest PE index first.
- R8: `done` is a one-cycle pulse. It rises one cycle after the last result write, and no write follows it.
- R9: A start pulse that arrives while a job is running is ignored.
- R10: Configuration inputs are sampled only at an accepted start, so changing them mid-job does not alter the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (ignored while busy) |
| filt_k | input | 2 | Filter edge K, 1..3 |
| stride_sel | input | 1 | 0: stride 1, 1: stride 2 |
| img_w | input | 8 | Padded tile width W |
| img_h | input | 8 | Padded tile height H |
| bias | input | 32 | Signed accumulator start value |
| pix_addr | output | NUM_PE*16 | Per-PE pixel buffer address |
| pix_data | input | NUM_PE*8 | Per-PE signed pixel, same cycle |
| wgt_idx | output | NUM_PE*4 | Per-PE weight index |
| wgt_data | input | NUM_PE*8 | Per-PE signed weight, same cycle |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 16 | Result address oy*OW+ox |
| wr_data | output | 32 | Signed result |
| done | output | 1 | Job complete pulse |

## Verification
A PE needs K² multiply cycles and at least one grant cycle per output. The write port adds one register stage, and `done` follows the last write strobe by exactly one cycle. Because of this, the bench does not predict per-result cycle numbers. It records every strobe at the falling edge and compares the whole result plane after `done`. It then waits several more cycles to confirm that nothing is written late. Timing itself is checked only as bounds: the first address written, the gap between start and done on a four-segment row, and the single-cycle width of `done`.

// File: rtl/conv_pkg.sv
package conv_pkg;
    localparam int DIM_W   = 8;
    localparam int ADDR_W  = 16;
    localparam int ACC_W   = 32;
    localparam int SEG_LEN = 16;
    localparam int CNT_W   = $clog2(SEG_LEN) + 1;

    typedef enum logic [1:0] {PE_IDLE, PE_MAC, PE_WAIT} pe_state_e;

    typedef struct packed {
        logic [1:0]              k;
        logic                    s2;
        logic [DIM_W-1:0]        w;
        logic [DIM_W-1:0]        ow;
        logic signed [ACC_W-1:0] bias;
    } cfg_t;

    typedef struct packed {
        logic [DIM_W-1:0] row;
        logic [DIM_W-1:0] x0;
        logic [CNT_W-1:0] len;
    } seg_t;
endpackage

// File: rtl/conv_pe.sv
module conv_pe
    import conv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  cfg_t                    cfg,
    input  logic                    go,
    input  seg_t                    seg,
    output logic                    busy,
    output logic [ADDR_W-1:0]       pix_addr,
    input  logic signed [7:0]       pix_data,
    output logic [3:0]              wgt_idx,
    input  logic signed [7:0]       wgt_data,
    output logic                    wr_req,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic signed [ACC_W-1:0] wr_data,
    input  logic                    grant,
    output logic                    seg_done
);
    typedef struct packed {
        pe_state_e               st;
        logic [DIM_W-1:0]        oy;
        logic [DIM_W-1:0]        ox;
        logic [DIM_W-1:0]        xlast;
        logic [1:0]              ky;
        logic [1:0]              kx;
        logic signed [ACC_W-1:0] acc;
    } pe_reg_t;

    pe_reg_t q, d;
    logic [ADDR_W-1:0] row_a, col_a;
    logic signed [15:0] prod;

    always_comb begin
        d        = q;
        seg_done = 1'b0;
        row_a    = (ADDR_W'(q.oy) << cfg.s2) + ADDR_W'(q.ky);
        col_a    = (ADDR_W'(q.ox) << cfg.s2) + ADDR_W'(q.kx);
        pix_addr = row_a * ADDR_W'(cfg.w) + col_a;
        wgt_idx  = {2'b00, q.ky} * {2'b00, cfg.k} + {2'b00, q.kx};
        prod     = pix_data * wgt_data;
        wr_req   = (q.st == PE_WAIT);
        wr_addr  = ADDR_W'(q.oy) * ADDR_W'(cfg.ow) + ADDR_W'(q.ox);
        wr_data  = q.acc;
        busy     = (q.st != PE_IDLE);
        unique case (q.st)
            PE_IDLE: begin
                if (go) begin
                    d.oy    = seg.row;
                    d.ox    = seg.x0;
                    d.xlast = DIM_W'(seg.x0 + DIM_W'(seg.len) - DIM_W'(1));
                    d.ky    = '0;
                    d.kx    = '0;
                    d.acc   = cfg.bias;
                    d.st    = PE_MAC;
                end
            end
            PE_MAC: begin
                d.acc = q.acc + ACC_W'(prod);
                if (q.kx == cfg.k - 2'd1) begin
                    d.kx = '0;
                    if (q.ky == cfg.k - 2'd1) begin
                        d.ky = '0;
                        d.st = PE_WAIT;
                    end else begin
                        d.ky = q.ky + 2'd1;
                    end
                end else begin
                    d.kx = q.kx + 2'd1;
                end
            end
            PE_WAIT: begin
                if (grant) begin
                    if (q.ox == q.xlast) begin
                        d.st     = PE_IDLE;
                        seg_done = 1'b1;
                    end else begin
                        d.ox  = q.ox + DIM_W'(1);
                        d.acc = cfg.bias;
                        d.st  = PE_MAC;
                    end
                end
            end
            default: d.st = PE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PE_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) grant |-> wr_req); // R7
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) go |-> (q.st == PE_IDLE)); // R6
    AST_TAP_IN_FILTER: assert property (@(posedge clk) disable iff (!rst_n) (q.st == PE_MAC) |-> (q.ky < cfg.k && q.kx < cfg.k)); // R4
endmodule

// File: rtl/conv_dispatch.sv
module conv_dispatch
    import conv_pkg::*;
#(
    parameter int NUM_PE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              k_in,
    input  logic                    s_in,
    input  logic [DIM_W-1:0]        w_in,
    input  logic [DIM_W-1:0]        h_in,
    input  logic signed [ACC_W-1:0] bias_in,
    input  logic [NUM_PE-1:0]       pe_busy,
    input  logic [NUM_PE-1:0]       seg_done,
    output cfg_t                    cfg,
    output logic [NUM_PE-1:0]       go,
    output seg_t                    seg,
    output logic                    done
);
    localparam int OUT_W = $clog2(NUM_PE + 1) + 1;

    typedef struct packed {
        logic             run;
        cfg_t             cfg;
        logic [DIM_W-1:0] oh;
        logic [DIM_W-1:0] row;
        logic [DIM_W-1:0] x0;
        logic             all_issued;
        logic [OUT_W-1:0] outst;
        logic             done;
    } disp_reg_t;

    disp_reg_t q, d;
    logic [NUM_PE-1:0] free_v;
    logic [DIM_W-1:0]  remain;
    logic              issue;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        free_v = ~pe_busy;
        go     = '0;
        issue  = 1'b0;
        remain = q.cfg.ow - q.x0;
        seg.row = q.row;
        seg.x0  = q.x0;
        seg.len = (remain >= DIM_W'(SEG_LEN)) ? CNT_W'(SEG_LEN) : CNT_W'(remain);
        if (!q.run) begin
            if (start) begin
                d.run        = 1'b1;
                d.cfg.k      = k_in;
                d.cfg.s2     = s_in;
                d.cfg.w      = w_in;
                d.cfg.bias   = bias_in;
                d.cfg.ow     = ((w_in - DIM_W'(k_in)) >> s_in) + DIM_W'(1);
                d.oh         = ((h_in - DIM_W'(k_in)) >> s_in) + DIM_W'(1);
                d.row        = '0;
                d.x0         = '0;
                d.all_issued = 1'b0;
                d.outst      = '0;
            end
        end else begin
            if (!q.all_issued && (|free_v)) begin
                go    = free_v & (~free_v + NUM_PE'(1));
                issue = 1'b1;
                if ({1'b0, q.x0} + (DIM_W+1)'(SEG_LEN) >= {1'b0, q.cfg.ow}) begin
                    d.x0 = '0;
                    if (q.row == q.oh - DIM_W'(1)) begin
                        d.all_issued = 1'b1;
                    end else begin
                        d.row = q.row + DIM_W'(1);
                    end
                end else begin
                    d.x0 = q.x0 + DIM_W'(SEG_LEN);
                end
            end
            d.outst = q.outst + OUT_W'(issue) - OUT_W'(|seg_done);
            if (q.all_issued && q.outst == '0) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
        cfg  = q.cfg;
        done = q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) q.done |-> (pe_busy == '0)); // R8
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (q.run && start) |=> $stable(q.cfg)); // R9
    AST_GO_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n) (go & pe_busy) == '0); // R6
endmodule

// File: rtl/conv_wr_arb.sv
module conv_wr_arb
    import conv_pkg::*;
#(
    parameter int NUM_PE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PE-1:0]        req,
    input  logic [NUM_PE*ADDR_W-1:0] req_addr,
    input  logic [NUM_PE*ACC_W-1:0]  req_data,
    output logic [NUM_PE-1:0]        grant,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [ACC_W-1:0]         wr_data
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [ACC_W-1:0]  data;
    } wr_reg_t;

    wr_reg_t q, d;

    always_comb begin
        grant  = req & (~req + NUM_PE'(1));
        d      = '0;
        d.en   = |req;
        for (int i = 0; i < NUM_PE; i++) begin
            if (grant[i]) begin
                d.addr = req_addr[i*ADDR_W +: ADDR_W];
                d.data = req_data[i*ACC_W +: ACC_W];
            end
        end
        wr_en   = q.en;
        wr_addr = q.addr;
        wr_data = q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/conv_tile_engine.sv
module conv_tile_engine
    import conv_pkg::*;
#(
    parameter int NUM_PE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               filt_k,
    input  logic                     stride_sel,
    input  logic [7:0]               img_w,
    input  logic [7:0]               img_h,
    input  logic [31:0]              bias,
    output logic [NUM_PE*16-1:0]     pix_addr,
    input  logic [NUM_PE*8-1:0]      pix_data,
    output logic [NUM_PE*4-1:0]      wgt_idx,
    input  logic [NUM_PE*8-1:0]      wgt_data,
    output logic                     wr_en,
    output logic [15:0]              wr_addr,
    output logic [31:0]              wr_data,
    output logic                     done
);
    cfg_t                     cfg;
    seg_t                     seg;
    logic [NUM_PE-1:0]        go, pe_busy, seg_done, req, grant;
    logic [NUM_PE*ADDR_W-1:0] req_addr;
    logic [NUM_PE*ACC_W-1:0]  req_data;

    conv_dispatch #(.NUM_PE(NUM_PE)) u_disp (
        .clk(clk), .rst_n(rst_n), .start(start),
        .k_in(filt_k), .s_in(stride_sel), .w_in(img_w), .h_in(img_h),
        .bias_in(signed'(bias)), .pe_busy(pe_busy), .seg_done(seg_done),
        .cfg(cfg), .go(go), .seg(seg), .done(done)
    );

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        conv_pe u_pe (
            .clk(clk), .rst_n(rst_n), .cfg(cfg), .go(go[p]), .seg(seg),
            .busy(pe_busy[p]),
            .pix_addr(pix_addr[p*ADDR_W +: ADDR_W]),
            .pix_data(signed'(pix_data[p*8 +: 8])),
            .wgt_idx(wgt_idx[p*4 +: 4]),
            .wgt_data(signed'(wgt_data[p*8 +: 8])),
            .wr_req(req[p]),
            .wr_addr(req_addr[p*ADDR_W +: ADDR_W]),
            .wr_data(req_data[p*ACC_W +: ACC_W]),
            .grant(grant[p]),
            .seg_done(seg_done[p])
        );
    end

    conv_wr_arb #(.NUM_PE(NUM_PE)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_data(req_data), .grant(grant),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: tb/conv_tile_engine_test.sv
module conv_tile_engine_test;
    localparam int NPE = 4;
    localparam int NV  = 7;
    localparam int TK[NV] = '{3, 1, 2, 3, 2, 3, 3};
    localparam int TS[NV] = '{0, 0, 1, 1, 0, 0, 0};
    localparam int TW[NV] = '{8, 20, 9, 37, 17, 3, 66};
    localparam int TH[NV] = '{6, 3, 9, 5, 2, 3, 3};
    localparam int TB[NV] = '{100, -5, 0, -1000, 7, -1, 3};

    logic clk = 0, rst_n = 0, start = 0, stride_sel = 0;
    logic [1:0] filt_k = 1;
    logic [7:0] img_w = 8, img_h = 8;
    logic [31:0] bias = 0;
    logic [NPE*16-1:0] pix_addr;
    logic [NPE*8-1:0]  pix_data, wgt_data;
    logic [NPE*4-1:0]  wgt_idx;
    logic wr_en, done;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;

    logic signed [7:0] pix_mem [0:1023];
    logic signed [7:0] wmem [0:8];
    int got [0:1023];
    int hits [0:1023];
    int ntests = 0, nfail = 0, cyc = 0, nwr = 0, ndone = 0, done_cyc = 0;
    int last_wr_cyc = 0, first_addr = -1, start_cyc = 0, done_width = 0;
    bit mon_on = 0;

    always #5 clk = ~clk;

    conv_tile_engine #(.NUM_PE(NPE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .filt_k(filt_k),
        .stride_sel(stride_sel), .img_w(img_w), .img_h(img_h), .bias(bias),
        .pix_addr(pix_addr), .pix_data(pix_data), .wgt_idx(wgt_idx),
        .wgt_data(wgt_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    always_comb begin
        for (int p = 0; p < NPE; p++) begin
            pix_data[p*8 +: 8] = pix_mem[pix_addr[p*16 +: 10]];
            wgt_data[p*8 +: 8] = (wgt_idx[p*4 +: 4] < 9) ? wmem[wgt_idx[p*4 +: 4]] : 8'sd0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (wr_en) begin
                if (wr_addr < 1024) begin
                    got[wr_addr] = signed'(wr_data);
                    hits[wr_addr]++;
                end
                if (first_addr < 0) first_addr = int'(wr_addr);
                nwr++;
                last_wr_cyc = cyc;
            end
            if (done) begin
                ndone++;
                done_cyc = cyc;
                done_width++;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(int k, int s, int w, int b, int oy, int ox);
        int acc = b;
        for (int ky = 0; ky < k; ky++)
            for (int kx = 0; kx < k; kx++)
                acc += int'(pix_mem[(oy*s+ky)*w + ox*s + kx]) * int'(wmem[ky*k+kx]);
        return acc;
    endfunction

    task automatic run_conv(int k, int s, int w, int h, int b, int seed,
                            bit restart, output int lat);
        int ow, oh, bad, bad_a, bad_v, bad_e, wait_c;
        for (int j = 0; j < 9; j++) wmem[j] = 8'(j*29 + seed*13 + 3);
        for (int a = 0; a < 1024; a++) begin got[a] = 0; hits[a] = 0; end
        nwr = 0; ndone = 0; first_addr = -1; done_width = 0; last_wr_cyc = 0;
        ow = (w - k) / (s + 1) + 1;
        oh = (h - k) / (s + 1) + 1;
        @(negedge clk);
        filt_k = 2'(k); stride_sel = s[0]; img_w = 8'(w); img_h = 8'(h); bias = 32'(b);
        mon_on = 1; start = 1; start_cyc = cyc;
        @(negedge clk);
        start = 0;
        if (restart) begin
            repeat (3) @(negedge clk);
            filt_k = 2'd1; stride_sel = 1'b0; img_w = 8'd20; img_h = 8'd3; bias = 32'd55;
            start = 1;
            @(negedge clk);
            start = 0;
        end
        wait_c = 0;
        while (ndone == 0 && wait_c < 20000) begin @(negedge clk); wait_c++; end
        repeat (6) @(negedge clk);
        mon_on = 0;
        lat = done_cyc - start_cyc;
        bad = 0; bad_a = 0; bad_v = 0; bad_e = 0;
        for (int oy = 0; oy < oh; oy++)
            for (int ox = 0; ox < ow; ox++) begin
                int a = oy*ow + ox;
                int e = model(k, s + 1, w, b, oy, ox);
                if ((hits[a] != 1 || got[a] != e) && bad == 0) begin
                    bad_a = a; bad_v = got[a]; bad_e = e;
                end
                if (hits[a] != 1 || got[a] != e) bad++;
            end
        chk(nwr == ow*oh, "R2 result count", nwr, ow*oh);
        chk(bad == 0, "R3 R4 R5 result value", bad_v, bad_e);
        if (bad != 0) $display("  first mismatch at address %0d, %0d bad", bad_a, bad);
        chk(ndone == 1 && done_width == 1, "R8 done single pulse", done_width, 1);
        chk(last_wr_cyc < done_cyc, "R8 no write at or after done", last_wr_cyc, done_cyc - 1);
        chk(first_addr == 0, "R6 raster start address", first_addr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        int lat;
        for (int i = 0; i < 1024; i++) pix_mem[i] = 8'(i*37 + 11);
        for (int j = 0; j < 9; j++) wmem[j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(wr_en == 0 && done == 0, "R1 reset outputs", int'({wr_en, done}), 0);
        mon_on = 1; nwr = 0; ndone = 0;
        repeat (10) @(negedge clk);
        mon_on = 0;
        chk(nwr == 0 && ndone == 0, "R1 idle without start", nwr + ndone, 0);

        for (int i = 0; i < NV; i++) begin
            run_conv(TK[i], TS[i], TW[i], TH[i], TB[i], i, 1'b0, lat);
            if (i == NV - 1)
                chk(lat < 320, "R7 four segments overlap", lat, 319);
        end

        run_conv(3, 0, 8, 6, 100, 9, 1'b1, lat);
        chk(lat < 400, "R9 R10 restart ignored latency", lat, 399);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule